// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a conditional-trap instruction fires. It receives the first source register value, a second register value, a 16-bit immediate, a flag that picks the immediate form, and a 3-bit condition code. It produces a trap request and a flag that marks an unassigned condition code. The two outputs are registered, so the result appears one clock after the operands are presented.

The register form and the immediate form share one condition-code table. In the immediate form the 16-bit immediate is always sign-extended to the data width before it is compared, and this includes the unsigned conditions, which then treat both 32-bit values as unsigned. The instruction decoder feeds this unit. The exception logic takes the trap request one cycle later.

Top module: `trap_cond_eval`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `trap_req` and `bad_code` are 0 after that edge.
- R2: The outputs after a rising edge reflect the inputs sampled at that edge, and they hold steady until the next edge (one cycle of latency).
- R3: Condition code 0 requests a trap when operand A is greater than or equal to operand B as two's-complement numbers.
- R4: Condition code 1 requests a trap when operand A is greater than or equal to operand B as unsigned numbers.
- R5: Condition code 2 requests a trap when operand A is less than operand B as two's-complement numbers.
- R6: Condition code 3 requests a trap when operand A is less than operand B as unsigned numbers.
- R7: Condition code 4 requests a trap when the operands are equal. Condition code 6 requests a trap when they differ.
- R8: When `use_imm` is 1, operand B is the sign-extended `imm` (bit 15 copied into bits 31..16), and `src_b` has no effect on the result. When `use_imm` is 0, operand B is `src_b`.
- R9: Under codes 1 and 3 with `use_imm` = 1, the immediate is still sign-extended before the unsigned compare. For example, 0xFFFF becomes 0xFFFFFFFF.
- R10: Codes 5 and 7 set `bad_code` to 1 and `trap_req` to 0. Codes 0, 1, 2, 3, 4 and 6 set `bad_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 32 | First operand (register value) |
| src_b | input | 32 | Second operand when the register form is used |
| imm | input | 16 | Immediate, sign-extended when the immediate form is used |
| use_imm | input | 1 | 1 selects the immediate form, 0 selects the register form |
| cond | input | 3 | Condition code (0 sge, 1 uge, 2 slt, 3 ult, 4 eq, 6 ne) |
| trap_req | output | 1 | Registered trap request |
| bad_code | output | 1 | Registered flag for an unassigned condition code |

## Verification
The only internal state is the pair of output registers. A fault there therefore appears on `trap_req` or `bad_code` one edge after the inputs that provoke it, either as a wrong value or as an early or late change. A wrong operand selection or a wrong sign extension looks like a trap decision that matches the other form or the other signedness. Operand pairs such as 0x7FFFFFFF against 0x80000000, and an all-ones immediate against a small register value, are chosen so that signed and unsigned decisions differ.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    TC_SGE = 3'd0,
    TC_UGE = 3'd1,
    TC_SLT = 3'd2,
    TC_ULT = 3'd3,
    TC_EQ  = 3'd4,
    TC_NE  = 3'd6
  } trap_cond_e;

  typedef struct packed {
    logic ge_s;
    logic ge_u;
    logic lt_s;
    logic lt_u;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/trap_operand_sel.sv
module trap_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output cmp_flags_t        flags
);
  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    lt_signed   = $signed(opnd_a) < $signed(opnd_b);
    lt_unsigned = opnd_a < opnd_b;
    flags.lt_s  = lt_signed;
    flags.lt_u  = lt_unsigned;
    flags.ge_s  = ~lt_signed;
    flags.ge_u  = ~lt_unsigned;
    flags.eq    = (opnd_a == opnd_b);
  end
endmodule

// File: rtl/trap_cond_decode.sv
module trap_cond_decode
  import trap_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  cmp_flags_t        flags,
  output logic              hit,
  output logic              illegal
);
  always_comb begin
    hit     = 1'b0;
    illegal = 1'b0;
    case (cond)
      TC_SGE:  hit = flags.ge_s;
      TC_UGE:  hit = flags.ge_u;
      TC_SLT:  hit = flags.lt_s;
      TC_ULT:  hit = flags.lt_u;
      TC_EQ:   hit = flags.eq;
      TC_NE:   hit = ~flags.eq;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic [COND_W-1:0] cond,
  output logic              trap_req,
  output logic              bad_code
);
  logic [DATA_W-1:0] opnd_b;
  cmp_flags_t        flags;
  logic              hit;
  logic              illegal;

  trap_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .reg_b   (src_b),
    .imm     (imm),
    .use_imm (use_imm),
    .opnd_b  (opnd_b)
  );

  trap_compare #(.DATA_W(DATA_W)) u_cmp (
    .opnd_a (src_a),
    .opnd_b (opnd_b),
    .flags  (flags)
  );

  trap_cond_decode u_dec (
    .cond    (cond),
    .flags   (flags),
    .hit     (hit),
    .illegal (illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      bad_code <= 1'b0;
    end else begin
      trap_req <= hit & ~illegal;
      bad_code <= illegal;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!trap_req && !bad_code)); // R1
  AST_NO_TRAP_WHEN_BAD: assert property (@(posedge clk) disable iff (rst) bad_code |-> !trap_req); // R10
  AST_UNASSIGNED_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cond == 3'd5 || cond == 3'd7) |=> (bad_code && !trap_req)); // R10
  AST_ASSIGNED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !(cond == 3'd5 || cond == 3'd7) |=> !bad_code); // R10
  AST_EQUAL_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (cond == 3'd4 && src_a == opnd_b) |=> trap_req); // R7
  AST_SGE_ON_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (cond == 3'd0 && src_a == opnd_b) |=> trap_req); // R3
  AST_ULT_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (cond == 3'd3 && opnd_b == '0) |=> !trap_req); // R6
  AST_IMM_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
    use_imm |-> (opnd_b[IMM_W-1:0] == imm && (opnd_b[DATA_W-1:IMM_W] == '0 || opnd_b[DATA_W-1:IMM_W] == '1))); // R8
endmodule

// File: tb/trap_cond_eval_test.sv
`timescale 1ns/1ps
module trap_cond_eval_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  cond = '0;
  logic        trap_req;
  logic        bad_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trap_cond_eval uut (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .imm(imm),
    .use_imm(use_imm), .cond(cond), .trap_req(trap_req), .bad_code(bad_code)
  );

  task automatic check(input logic exp_t, input logic exp_b, input string req);
    checks++;
    if (trap_req !== exp_t || bad_code !== exp_b) begin
      fails++;
      $display("FAIL %s: trap=%0b bad=%0b expected trap=%0b bad=%0b",
               req, trap_req, bad_code, exp_t, exp_b);
    end
  endtask

  // drive on a falling edge, let one rising edge capture, sample 1 ns later
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [15:0] i,
                       input logic ui, input logic [2:0] c);
    @(negedge clk);
    src_a = a; src_b = b; imm = i; use_imm = ui; cond = c;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(32'h5, 32'h5, 16'h0, 1'b0, 3'd4);
    check(1'b0, 1'b0, "R1 reset state");
    drive(32'h0, 32'h0, 16'h0, 1'b0, 3'd5);
    check(1'b0, 1'b0, "R1 reset masks bad code");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_boundary_signedness();
    drive(32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0, 3'd0);
    check(1'b1, 1'b0, "R3 sge max vs min");
    drive(32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0, 3'd1);
    check(1'b0, 1'b0, "R4 uge max vs min");
    drive(32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0, 3'd2);
    check(1'b0, 1'b0, "R5 slt max vs min");
    drive(32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0, 3'd3);
    check(1'b1, 1'b0, "R6 ult max vs min");
    drive(32'hFFFFFFFF, 32'h00000001, 16'h0, 1'b0, 3'd2);
    check(1'b1, 1'b0, "R5 slt -1 vs 1");
    drive(32'hFFFFFFFF, 32'h00000001, 16'h0, 1'b0, 3'd1);
    check(1'b1, 1'b0, "R4 uge all-ones vs 1");
    drive(32'h00000010, 32'h00000010, 16'h0, 1'b0, 3'd3);
    check(1'b0, 1'b0, "R6 ult equal operands");
    drive(32'h00000010, 32'h00000010, 16'h0, 1'b0, 3'd0);
    check(1'b1, 1'b0, "R3 sge equal operands");
  endtask

  task automatic t_equality();
    drive(32'hDEADBEEF, 32'hDEADBEEF, 16'h0, 1'b0, 3'd4);
    check(1'b1, 1'b0, "R7 eq same");
    drive(32'hDEADBEEF, 32'hDEADBEEE, 16'h0, 1'b0, 3'd4);
    check(1'b0, 1'b0, "R7 eq differ");
    drive(32'hDEADBEEF, 32'hDEADBEEE, 16'h0, 1'b0, 3'd6);
    check(1'b1, 1'b0, "R7 ne differ");
    drive(32'h0, 32'h0, 16'h0, 1'b0, 3'd6);
    check(1'b0, 1'b0, "R7 ne same");
  endtask

  task automatic t_immediate();
    drive(32'h5, 32'h5, 16'h0007, 1'b1, 3'd4);
    check(1'b0, 1'b0, "R8 src_b ignored in imm form");
    drive(32'h7, 32'h5, 16'h0007, 1'b1, 3'd4);
    check(1'b1, 1'b0, "R8 imm equals a");
    drive(32'hFFFF8000, 32'h0, 16'h8000, 1'b1, 3'd4);
    check(1'b1, 1'b0, "R8 negative imm sign-extended");
    drive(32'h5, 32'h0, 16'hFFFF, 1'b1, 3'd0);
    check(1'b1, 1'b0, "R8 sge 5 vs imm -1");
    drive(32'h5, 32'h0, 16'hFFFF, 1'b1, 3'd1);
    check(1'b0, 1'b0, "R9 uge 5 vs extended all-ones");
    drive(32'h5, 32'h0, 16'hFFFF, 1'b1, 3'd3);
    check(1'b1, 1'b0, "R9 ult 5 vs extended all-ones");
    drive(32'h0000FFFF, 32'h0, 16'hFFFF, 1'b1, 3'd3);
    check(1'b1, 1'b0, "R9 ult 0xFFFF vs 0xFFFFFFFF");
  endtask

  task automatic t_bad_codes();
    drive(32'h1, 32'h1, 16'h0, 1'b0, 3'd5);
    check(1'b0, 1'b1, "R10 code 5");
    drive(32'h1, 32'h2, 16'h1, 1'b1, 3'd7);
    check(1'b0, 1'b1, "R10 code 7");
    drive(32'h1, 32'h2, 16'h0, 1'b0, 3'd6);
    check(1'b1, 1'b0, "R10 legal code clears flag");
  endtask

  task automatic t_latency();
    drive(32'h3, 32'h3, 16'h0, 1'b0, 3'd4);
    check(1'b1, 1'b0, "R2 setup");
    @(negedge clk);
    src_b = 32'h4;
    #1;
    check(1'b1, 1'b0, "R2 holds before edge");
    @(posedge clk); #1;
    check(1'b0, 1'b0, "R2 updates after edge");
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_boundary_signedness();
    t_equality();
    t_immediate();
    t_bad_codes();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule